// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This controller takes an external audio codec from reset to a running clock tree in PLL slave mode. After one start pulse it keeps the codec's active-low power-down pin low for a minimum time and then releases it. Next it sends a fixed script of four configuration register writes: two for interface format, PLL reference and sample rate, then one that powers up the common-mode reference, then one that turns on the codec's PLL and master-clock output together. It then waits out the worst-case PLL lock interval. Only after that does it open the enables for the bit-clock and frame-clock generators and raise a sticky done flag.

The register writes leave through a valid/ready port that carries an 8-bit address and an 8-bit data byte. A word moves only in a cycle where both valid and ready are high. While ready is low the sequencer holds the same word and waits with no time limit. The I2C or SPI engine that sits behind this port is a separate block. The reset-hold and lock-wait cycle counts are computed from the controller clock frequency and are always rounded up.

Top module: `acps_powerup_seq`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the cycle after it, codec_pdn_n, cfg_valid, bclk_en, lrclk_en, busy and done are all low.
- R2: A start pulse in the idle state raises busy in the next cycle. codec_pdn_n then stays low for exactly HOLD_CYC cycles counted from that busy cycle. After that it goes high and stays high until reset.
- R3: The writes are presented in a fixed order of (address, data): (04h, 4Ah), (05h, 27h), (00h, 40h), (01h, 03h). The first one is presented in the same cycle that codec_pdn_n goes high.
- R4: Once cfg_valid is high with a word, it stays high with the same cfg_addr and cfg_data until a cycle in which cfg_ready is also high. While cfg_ready stays low the sequencer waits with no limit. cfg_valid is low whenever codec_pdn_n is low and after the last word is accepted.
- R5: done rises exactly LOCK_CYC clock edges after the edge that accepts the final write (01h, 03h).
- R6: bclk_en and lrclk_en stay low until done is high. They rise in the same cycle as done.
- R7: Once done is high, it stays high until reset. From then on busy is low and codec_pdn_n, bclk_en and lrclk_en stay high.
- R8: A start pulse has no effect while busy is high or after done. The write script, the cycle counts and the outputs are unchanged by it.
- R9: HOLD_CYC = ceil(HOLD_NS * CLK_HZ / 1e9) and LOCK_CYC = ceil(LOCK_NS * CLK_HZ / 1e9). The result is rounded up, never down, and is at least 1.
- R10: A reset in the middle of a sequence aborts it. On the next cycle the outputs return to the R1 state, and a new start runs the whole sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin the power-up sequence |
| codec_pdn_n | output | 1 | Active-low power-down pin to the codec |
| cfg_addr | output | 8 | Register address of the presented write |
| cfg_data | output | 8 | Register data of the presented write |
| cfg_valid | output | 1 | A write word is presented |
| cfg_ready | input | 1 | The serial control engine accepts the presented word |
| bclk_en | output | 1 | Enable for the bit-clock generator |
| lrclk_en | output | 1 | Enable for the frame-clock generator |
| busy | output | 1 | High from the cycle after an accepted start until done |
| done | output | 1 | Sticky sequence-complete flag |

## Verification
The assertions assume that cfg_ready is a clean synchronous level and that it may stay low for any length of time. They also assume that reset is held for at least one edge at time zero. The stimulus drives cfg_ready from a seeded random draw at several acceptance rates and adds a directed stall of several dozen cycles on one word. It raises start pulses at random points during the hold, write and lock phases and after done, to check that a busy or finished sequencer ignores them. A mid-sequence reset is applied once and followed by a clean rerun.

// File: rtl/acps_pkg.sv
package acps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WRITE,
    ST_LOCK,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } cfg_word_t;

  localparam int unsigned SCRIPT_LEN = 4;

  // Fixed start-up script; the order is the behaviour (reference before PLL).
  function automatic cfg_word_t script_word(input int unsigned idx);
    cfg_word_t w;
    case (idx)
      0:       w = {8'h04, 8'h4A};
      1:       w = {8'h05, 8'h27};
      2:       w = {8'h00, 8'h40};
      3:       w = {8'h01, 8'h03};
      default: w = '0;
    endcase
    return w;
  endfunction

  // Minimum time in ns to clock cycles, rounded up, never below one.
  function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                   input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/acps_interval_timer.sv
module acps_interval_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - TW'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/acps_cfg_writer.sv
module acps_cfg_writer
  import acps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] addr,
  output logic [7:0] data,
  output logic       last_accept
);

  localparam int unsigned IW = (SCRIPT_LEN > 1) ? $clog2(SCRIPT_LEN) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(SCRIPT_LEN - 1);

  logic [IW-1:0] idx;
  cfg_word_t     word;
  logic          accept;

  assign valid  = active;
  assign accept = active && ready;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      idx <= '0;
    end else if (accept && idx != LAST_IDX) begin
      idx <= idx + IW'(1);
    end
  end

  always_comb begin
    word = script_word(32'(idx));
  end

  assign addr        = word.addr;
  assign data        = word.data;
  assign last_accept = accept && (idx == LAST_IDX);

endmodule

// File: rtl/acps_seq_ctrl.sv
module acps_seq_ctrl
  import acps_pkg::*;
#(
  parameter int unsigned TW          = 8,
  parameter logic [TW-1:0] HOLD_VAL  = 1,
  parameter logic [TW-1:0] LOCK_VAL  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          timer_expired,
  input  logic          last_accept,
  output logic          timer_load,
  output logic [TW-1:0] timer_val,
  output logic          write_active,
  output logic          pdn_n,
  output logic          clk_en,
  output logic          busy,
  output logic          done
);

  seq_state_e state, next;

  always_comb begin
    next       = state;
    timer_load = 1'b0;
    timer_val  = HOLD_VAL;
    case (state)
      ST_IDLE: begin
        if (start) begin
          next       = ST_HOLD;
          timer_load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (timer_expired) next = ST_WRITE;
      end
      ST_WRITE: begin
        if (last_accept) begin
          next       = ST_LOCK;
          timer_load = 1'b1;
          timer_val  = LOCK_VAL;
        end
      end
      ST_LOCK: begin
        if (timer_expired) next = ST_DONE;
      end
      ST_DONE: next = ST_DONE;
      default: next = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pdn_n  <= 1'b0;
      clk_en <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= next;
      pdn_n  <= (next == ST_WRITE) || (next == ST_LOCK) || (next == ST_DONE);
      clk_en <= (next == ST_DONE);
      done   <= (next == ST_DONE);
      busy   <= (next == ST_HOLD) || (next == ST_WRITE) || (next == ST_LOCK);
    end
  end

  assign write_active = (state == ST_WRITE);

endmodule

// File: rtl/acps_powerup_seq.sv
module acps_powerup_seq #(
  parameter longint unsigned CLK_HZ  = 100_000_000,
  parameter longint unsigned HOLD_NS = 150,
  parameter longint unsigned LOCK_NS = 40_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       codec_pdn_n,
  output logic [7:0] cfg_addr,
  output logic [7:0] cfg_data,
  output logic       cfg_valid,
  input  logic       cfg_ready,
  output logic       bclk_en,
  output logic       lrclk_en,
  output logic       busy,
  output logic       done
);

  localparam longint unsigned HOLD_CYC = acps_pkg::ns_to_cycles(HOLD_NS, CLK_HZ);
  localparam longint unsigned LOCK_CYC = acps_pkg::ns_to_cycles(LOCK_NS, CLK_HZ);
  localparam longint unsigned MAX_CYC  = (HOLD_CYC > LOCK_CYC) ? HOLD_CYC : LOCK_CYC;
  localparam int unsigned     TW       = $clog2(MAX_CYC + 1);

  logic          timer_load;
  logic [TW-1:0] timer_val;
  logic          timer_expired;
  logic          write_active;
  logic          last_accept;
  logic          clk_en;

  acps_seq_ctrl #(
    .TW       (TW),
    .HOLD_VAL (TW'(HOLD_CYC)),
    .LOCK_VAL (TW'(LOCK_CYC))
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .timer_expired (timer_expired),
    .last_accept   (last_accept),
    .timer_load    (timer_load),
    .timer_val     (timer_val),
    .write_active  (write_active),
    .pdn_n         (codec_pdn_n),
    .clk_en        (clk_en),
    .busy          (busy),
    .done          (done)
  );

  acps_interval_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  acps_cfg_writer u_writer (
    .clk         (clk),
    .rst         (rst),
    .active      (write_active),
    .ready       (cfg_ready),
    .valid       (cfg_valid),
    .addr        (cfg_addr),
    .data        (cfg_data),
    .last_accept (last_accept)
  );

  assign bclk_en  = clk_en;
  assign lrclk_en = clk_en;

endmodule

// File: rtl/acps_powerup_seq_chk.sv
module acps_powerup_seq_chk #(
  parameter longint unsigned HOLD_CYC = 1,
  parameter longint unsigned LOCK_CYC = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       codec_pdn_n,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_data,
  input logic       cfg_valid,
  input logic       cfg_ready,
  input logic       bclk_en,
  input logic       lrclk_en,
  input logic       busy,
  input logic       done
);

  logic [31:0] hold_cnt;
  logic [31:0] lock_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      lock_cnt <= '0;
    end else begin
      if (busy && !codec_pdn_n) hold_cnt <= hold_cnt + 32'd1;
      if (cfg_valid)                lock_cnt <= '0;
      else if (busy && codec_pdn_n) lock_cnt <= lock_cnt + 32'd1;
    end
  end

  assert_hold_min_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(codec_pdn_n) |-> (hold_cnt >= 32'(HOLD_CYC)));

  assert_pdn_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    codec_pdn_n |=> codec_pdn_n);

  assert_word_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr) && $stable(cfg_data)));

  assert_valid_gated_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (codec_pdn_n && busy));

  assert_lock_wait_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (lock_cnt >= 32'(LOCK_CYC)));

  assert_clk_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (bclk_en == done) && (lrclk_en == done));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !busy && codec_pdn_n));

  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

endmodule

bind acps_powerup_seq acps_powerup_seq_chk #(
  .HOLD_CYC (HOLD_CYC),
  .LOCK_CYC (LOCK_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .codec_pdn_n (codec_pdn_n),
  .cfg_addr    (cfg_addr),
  .cfg_data    (cfg_data),
  .cfg_valid   (cfg_valid),
  .cfg_ready   (cfg_ready),
  .bclk_en     (bclk_en),
  .lrclk_en    (lrclk_en),
  .busy        (busy),
  .done        (done)
);

// File: tb/acps_powerup_seq_bench.sv
`timescale 1ns/1ps
module acps_powerup_seq_bench;

  localparam int HOLD_NS_T = 152;
  localparam int LOCK_NS_T = 20_000;
  localparam int PERIOD_NS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       cfg_ready = 1'b0;
  logic       codec_pdn_n, cfg_valid, bclk_en, lrclk_en, busy, done;
  logic [7:0] cfg_addr, cfg_data;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acps_powerup_seq #(
    .CLK_HZ  (200_000_000),
    .HOLD_NS (HOLD_NS_T),
    .LOCK_NS (LOCK_NS_T)
  ) u_acps_powerup_seq (
    .clk (clk), .rst (rst), .start (start),
    .codec_pdn_n (codec_pdn_n), .cfg_addr (cfg_addr), .cfg_data (cfg_data),
    .cfg_valid (cfg_valid), .cfg_ready (cfg_ready),
    .bclk_en (bclk_en), .lrclk_en (lrclk_en), .busy (busy), .done (done)
  );

  function automatic int ceil_cycles(input int ns);
    return (ns + PERIOD_NS - 1) / PERIOD_NS;
  endfunction

  function automatic logic [15:0] exp_word(input int k);
    case (k)
      0: return 16'h044A;
      1: return 16'h0527;
      2: return 16'h0040;
      3: return 16'h0103;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle_outputs(input string req);
    check(!codec_pdn_n && !cfg_valid && !bclk_en && !lrclk_en && !busy && !done, req,
          {codec_pdn_n, cfg_valid, bclk_en, lrclk_en, busy, done}, 0);
  endtask

  // One full sequence from idle. ready_pct: acceptance chance; stall: cycles
  // ready is held low on word 1; poke: random start pulses while busy.
  task automatic run_seq(input int ready_pct, input int stall, input bit poke);
    int hold_cnt = 0;
    int lock_cnt = 0;
    int wr_idx = 0;
    int stall_left = stall;
    bit pdn_seen = 0, locking = 0, prev_stall = 0, ended = 0;
    logic [15:0] prev_w = '0;
    int exp_hold = ceil_cycles(HOLD_NS_T);
    int exp_lock = ceil_cycles(LOCK_NS_T);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 20000 && !ended; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (cyc == 0) check(busy && !codec_pdn_n, "R2 busy after start", {busy, codec_pdn_n}, 2'b10);
      if (busy && !codec_pdn_n) hold_cnt++;
      if (codec_pdn_n && !pdn_seen) begin
        pdn_seen = 1;
        check(hold_cnt == exp_hold, "R2/R9 reset hold cycles", hold_cnt, exp_hold);
        check(cfg_valid, "R3 first word with pdn release", cfg_valid, 1);
      end
      if (pdn_seen && !codec_pdn_n) check(0, "R2 pdn dropped", 0, 1);
      if (prev_stall)
        check(cfg_valid && {cfg_addr, cfg_data} == prev_w, "R4 word held under stall",
              {cfg_addr, cfg_data}, prev_w);
      if (!done) check(!bclk_en && !lrclk_en, "R6 clocks gated", {bclk_en, lrclk_en}, 0);
      if (locking) begin
        if (cfg_valid) check(0, "R4 valid after last word", 1, 0);
        if (done) begin
          check(lock_cnt == exp_lock, "R5/R9 lock wait cycles", lock_cnt, exp_lock);
          check(bclk_en && lrclk_en, "R6 clocks open with done", {bclk_en, lrclk_en}, 2'b11);
          ended = 1;
        end
        lock_cnt++;
      end
      if (cfg_valid && !locking)
        check({cfg_addr, cfg_data} == exp_word(wr_idx), "R3 write order",
              {cfg_addr, cfg_data}, exp_word(wr_idx));
      if (!ended) begin
        if (wr_idx == 1 && stall_left > 0) begin
          cfg_ready = 1'b0;
          stall_left--;
        end else begin
          cfg_ready = (($urandom % 100) < ready_pct);
        end
        start = poke && (($urandom % 8) == 0);
        if (cfg_valid && cfg_ready) begin
          wr_idx++;
          if (wr_idx == 4) begin
            locking = 1;
            lock_cnt = 0;
          end
        end
        prev_stall = cfg_valid && !cfg_ready;
        prev_w = {cfg_addr, cfg_data};
      end
    end
    start = 1'b0;
    check(ended && wr_idx == 4, "R3 four writes then done", wr_idx, 4);
    // Done phase: start is ignored and everything stays put.
    for (int k = 0; k < 24; k++) begin
      start = (k % 3 == 0);
      cfg_ready = 1'b1;
      @(negedge clk);
      if (!(done && !busy && codec_pdn_n && bclk_en && lrclk_en && !cfg_valid)) begin
        check(0, "R7/R8 done state disturbed",
              {done, busy, codec_pdn_n, bclk_en, lrclk_en, cfg_valid}, 6'b101110);
      end
    end
    start = 1'b0;
    check(done && !busy && !cfg_valid, "R7/R8 done sticky after start pulses",
          {done, busy, cfg_valid}, 3'b100);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start = 1'b0;
    cfg_ready = 1'b0;
    @(negedge clk);
    check_idle_outputs("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle_outputs("R1 after reset");
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();

    run_seq(100, 0, 0);
    do_reset();
    run_seq(35, 60, 1);
    do_reset();
    run_seq(70, 5, 1);

    // R10: abort mid-write, then a clean rerun.
    do_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 40; k++) @(negedge clk);
    check(codec_pdn_n && cfg_valid, "R10 inside write phase", {codec_pdn_n, cfg_valid}, 2'b11);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle_outputs("R10 abort clears outputs");
    @(negedge clk);
    check_idle_outputs("R10 stays idle without start");
    run_seq(50, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(200_000 * PERIOD_NS);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule